// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block supervises host software with a single watchdog byte. The byte holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout, counted in sixteenths of a second, is the multiplier times four raised to the resolution code. The count advances only on a 16 Hz enable strobe supplied from outside. Software keeps the count from expiring by writing the watchdog byte again, or by reading it back.

When the count runs out, a sticky timeout flag is set. The steering bit then chooses the action. With the bit clear, the block raises a one-cycle interrupt pulse. With the bit set, the block raises a one-cycle reset request, clears the watchdog byte and clears one marker bit in a companion keep register. The watchdog fires once per arming and does not restart by itself.

Host access uses a small register port with a 2-bit select, write and read strobes, and combinational read data. The select codes are: 0 for the watchdog byte (read/write), 1 for the flags (read-only, bit 7 is the timeout flag), 2 for the keep register (read/write, bit 6 is the marker) and 3 for an unused slot that reads zero.

Top module: `wdog_timer`

## Requirements
- R1: The watchdog byte is decoded as follows: bits [1:0] are the resolution code r, bits [6:2] are the multiplier m and bit 7 steers the action. A write of a nonzero m arms the count. The first expiry follows exactly m·4^r enable strobes.
- R2: A write whose multiplier field is zero, including a write of zero, leaves the watchdog disarmed. No interrupt or reset request follows, however many strobes arrive.
- R3: A write to select 0 stores the byte, clears the timeout flag and restarts the count from the new value.
- R4: A read strobe on select 0 restarts the count from the stored byte and leaves the stored byte unchanged.
- R5: On expiry, flag bit 7 (select 1) becomes 1. The watchdog then stays disarmed until the next write or read of select 0.
- R6: On expiry with steering bit 7 set, resetReq is high for exactly one clock cycle, the watchdog byte reads 0, keep-register bit 6 reads 0 and irqPulse stays low.
- R7: On expiry with steering bit 7 clear, irqPulse is high for exactly one clock cycle, resetReq stays low and the watchdog byte keeps its value.
- R8: Host writes to select 1 have no effect on the flags.
- R9: A write or read of select 0 in the same cycle as an enable strobe takes precedence. That strobe is not counted and does not cause an expiry.
- R10: The keep register is written and read through select 2. Select 3 reads 0. The outputs and all registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 16 Hz time-base enable, one cycle per step |
| regSel | input | 2 | Register select |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (side effect on select 0) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for regSel |
| irqPulse | output | 1 | One-cycle timeout interrupt |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that wrEn and rdEn are never high together, and that tickEn is a single-cycle strobe. The properties on flag stability and pulse width rely on both. The bench drives each host access as one isolated strobe cycle and each enable step as a one-cycle pulse with an idle cycle after it. Only the precedence test places a strobe in the same cycle as a host access, and that case stays within these assumptions.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int RES_W  = 2;
  parameter int MULT_W = 5;
  localparam int REG_W = 1 + MULT_W + RES_W;
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);
  localparam int STEER_BIT = REG_W - 1;
  localparam int FLAG_BIT = 7;
  localparam int MARK_BIT = 6;

  typedef enum logic [1:0] {
    SEL_WDOG  = 2'd0,
    SEL_FLAGS = 2'd1,
    SEL_KEEP  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadNew;
    logic reloadOld;
    logic decrement;
    logic expire;
    logic expireReset;
    logic keepWrite;
  } wdStrobe_t;

  function automatic logic [MULT_W-1:0] multOf(input logic [REG_W-1:0] v);
    return v[RES_W +: MULT_W];
  endfunction

  function automatic logic [CNT_W-1:0] ticksOf(input logic [REG_W-1:0] v);
    logic [CNT_W-1:0] base;
    base = {{(CNT_W-MULT_W){1'b0}}, v[RES_W +: MULT_W]};
    return base << (2 * v[RES_W-1:0]);
  endfunction
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       tickEn,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       armed,
  input  logic       countIsOne,
  input  logic       steer,
  output wdStrobe_t  strobe
);
  logic hitWdog;
  logic hostTouch;

  always_comb begin
    hitWdog   = (regSel == SEL_WDOG);
    hostTouch = hitWdog && (wrEn || rdEn);
    strobe = '0;
    strobe.loadNew     = hitWdog && wrEn;
    strobe.reloadOld   = hitWdog && rdEn && !wrEn;
    strobe.decrement   = tickEn && armed && !hostTouch;
    strobe.expire      = strobe.decrement && countIsOne;
    strobe.expireReset = strobe.expire && steer;
    strobe.keepWrite   = wrEn && (regSel == SEL_KEEP);
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [1:0]       regSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irqPulse,
  output logic             resetReq,
  output logic [REG_W-1:0] wdRegQ,
  output logic [REG_W-1:0] keepQ,
  output logic             flagQ,
  output logic             armedQ,
  output logic [CNT_W-1:0] countQ,
  output logic             countIsOne,
  output logic             steer
);
  logic [REG_W-1:0] loadSrc;

  assign loadSrc    = strobe.loadNew ? wrData : wdRegQ;
  assign countIsOne = (countQ == CNT_W'(1));
  assign steer      = wdRegQ[STEER_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdRegQ <= '0;
    end else if (strobe.loadNew) begin
      wdRegQ <= wrData;
    end else if (strobe.expireReset) begin
      wdRegQ <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keepQ <= '0;
    end else begin
      if (strobe.keepWrite) keepQ <= wrData;
      if (strobe.expireReset) keepQ[MARK_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobe.loadNew) begin
      flagQ <= 1'b0;
    end else if (strobe.expire) begin
      flagQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      countQ <= '0;
    end else if (strobe.loadNew || strobe.reloadOld) begin
      armedQ <= (multOf(loadSrc) != '0);
      countQ <= ticksOf(loadSrc);
    end else if (strobe.expire) begin
      armedQ <= 1'b0;
      countQ <= '0;
    end else if (strobe.decrement) begin
      countQ <= countQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      irqPulse <= strobe.expire && !strobe.expireReset;
      resetReq <= strobe.expireReset;
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_WDOG:  rdData = wdRegQ;
      SEL_FLAGS: rdData[FLAG_BIT] = flagQ;
      SEL_KEEP:  rdData = keepQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irqPulse,
  output logic       resetReq
);
  wdStrobe_t        strobe;
  logic [REG_W-1:0] wdRegQ;
  logic [REG_W-1:0] keepQ;
  logic             flagQ;
  logic             armedQ;
  logic [CNT_W-1:0] countQ;
  logic             countIsOne;
  logic             steer;

  wdog_ctrl u_ctrl (
    .tickEn(tickEn), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .armed(armedQ), .countIsOne(countIsOne), .steer(steer), .strobe(strobe)
  );

  wdog_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .irqPulse(irqPulse),
    .resetReq(resetReq), .wdRegQ(wdRegQ), .keepQ(keepQ), .flagQ(flagQ),
    .armedQ(armedQ), .countQ(countQ), .countIsOne(countIsOne), .steer(steer)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic [1:0]       regSel,
  input logic             wrEn,
  input logic             irqPulse,
  input logic             resetReq,
  input logic [REG_W-1:0] wdRegQ,
  input logic [REG_W-1:0] keepQ,
  input logic             flagQ,
  input logic             armedQ,
  input logic [CNT_W-1:0] countQ
);
  AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (countQ != '0)); // R1
  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(irqPulse && resetReq)); // R6
  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse || resetReq) |-> flagQ); // R5
  AST_EVENT_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse || resetReq) |-> !armedQ); // R5
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R6
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (wdRegQ == '0 && !keepQ[MARK_BIT])); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R7
  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_WDOG) |=> !flagQ); // R3
  AST_FLAGS_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_FLAGS && !tickEn) |=> $stable(flagQ)); // R8
endmodule

bind wdog_timer wdog_checker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regSel(regSel), .wrEn(wrEn),
  .irqPulse(irqPulse), .resetReq(resetReq), .wdRegQ(wdRegQ), .keepQ(keepQ),
  .flagQ(flagQ), .armedQ(armedQ), .countQ(countQ)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irqPulse;
  logic       resetReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam int NVEC = 6;
  localparam logic [7:0] VEC_VAL [NVEC] = '{8'h04, 8'h0D, 8'h16, 8'h07, 8'h7C, 8'h0B};
  localparam int VEC_TICKS [NVEC] = '{1, 12, 80, 64, 31, 128};

  always #2.5 clk = ~clk;

  wdog_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regSel(regSel), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irqPulse(irqPulse),
    .resetReq(resetReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    regSel = sel; wrData = val; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] val);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    #1 val = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic tick(output bit sawIrq, output bit sawRst);
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    sawIrq = irqPulse;
    sawRst = resetReq;
  endtask

  task automatic ticksUntilEvent(input int limit, output int firstAt, output bit anyRst);
    bit i1, r1;
    firstAt = 0; anyRst = 1'b0;
    for (int n = 1; n <= limit; n++) begin
      tick(i1, r1);
      if (r1) anyRst = 1'b1;
      if ((i1 || r1) && firstAt == 0) begin
        firstAt = n;
        break;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int at;
    bit anyRst, i1, r1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    check(irqPulse == 0 && resetReq == 0, "R10 outputs after reset", {irqPulse, resetReq}, 0);
    readReg(2'd0, v); check(v == 8'h00, "R10 wdog reg reset", v, 0);
    readReg(2'd1, v); check(v == 8'h00, "R10 flags reset", v, 0);
    readReg(2'd2, v); check(v == 8'h00, "R10 keep reg reset", v, 0);

    // R1 / R5 / R7 vector table
    for (int k = 0; k < NVEC; k++) begin
      writeReg(2'd0, VEC_VAL[k]);
      readReg(2'd1, v); check(v[7] == 0, "R3 flag clear after write", v, 0);
      ticksUntilEvent(VEC_TICKS[k] + 2, at, anyRst);
      check(at == VEC_TICKS[k], "R1 timeout length", at, VEC_TICKS[k]);
      check(!anyRst, "R7 no reset request", anyRst, 0);
      @(negedge clk);
      check(irqPulse == 0, "R7 irq lasts one cycle", irqPulse, 0);
      readReg(2'd1, v); check(v[7] == 1, "R5 flag set on expiry", v, 8'h80);
      tick(i1, r1); check(!i1 && !r1, "R5 one-shot after expiry", {i1, r1}, 0);
      readReg(2'd0, v); check(v == VEC_VAL[k], "R7 wdog reg kept", v, VEC_VAL[k]);
    end

    // R8 flags not writable (flag currently 1)
    writeReg(2'd1, 8'h00);
    readReg(2'd1, v); check(v == 8'h80, "R8 flag write ignored (1)", v, 8'h80);
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'hFF);
    readReg(2'd1, v); check(v == 8'h00, "R8 flag write ignored (0)", v, 0);

    // R2 disabled settings
    writeReg(2'd0, 8'h00);
    ticksUntilEvent(40, at, anyRst); check(at == 0, "R2 zero write disables", at, 0);
    writeReg(2'd0, 8'h83);
    ticksUntilEvent(40, at, anyRst); check(at == 0, "R2 zero multiplier disables", at, 0);

    // R6 reset-steered expiry
    writeReg(2'd2, 8'hFF);
    writeReg(2'd0, 8'h88);
    ticksUntilEvent(4, at, anyRst);
    check(at == 2 && anyRst, "R6 reset request after 2 steps", at, 2);
    check(irqPulse == 0, "R6 no irq", irqPulse, 0);
    @(negedge clk);
    check(resetReq == 0, "R6 reset request one cycle", resetReq, 0);
    readReg(2'd2, v); check(v == 8'hBF, "R6 keep bit 6 cleared", v, 8'hBF);
    readReg(2'd1, v); check(v == 8'h80, "R5 flag set by reset expiry", v, 8'h80);
    readReg(2'd0, v); check(v == 8'h00, "R6 wdog reg cleared", v, 0);
    ticksUntilEvent(10, at, anyRst); check(at == 0, "R6 stays disarmed", at, 0);

    // R4 read restarts with stored value
    writeReg(2'd0, 8'h10);
    for (int n = 0; n < 3; n++) tick(i1, r1);
    readReg(2'd0, v); check(v == 8'h10, "R4 read keeps value", v, 8'h10);
    ticksUntilEvent(6, at, anyRst); check(at == 4, "R4 read restarts count", at, 4);

    // R3 write restarts with new value
    writeReg(2'd0, 8'h10);
    for (int n = 0; n < 3; n++) tick(i1, r1);
    writeReg(2'd0, 8'h0C);
    ticksUntilEvent(6, at, anyRst); check(at == 3, "R3 write restarts count", at, 3);

    // R9 host access beats a coincident strobe
    writeReg(2'd0, 8'h04);
    @(negedge clk);
    regSel = 2'd0; wrData = 8'h08; wrEn = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    check(irqPulse == 0, "R9 coincident strobe ignored", irqPulse, 0);
    ticksUntilEvent(4, at, anyRst); check(at == 2, "R9 count from new value", at, 2);

    // R10 unused select
    readReg(2'd3, v); check(v == 8'h00, "R10 unused select reads zero", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule